// File: doc/BRIEF.md
# I2C Line Override and Stuck-Bus Recovery Unit

This unit sits between an I2C master core and the SCL/SDA pad drivers. In normal operation both pad drive levels pass straight through from the core. Software can take either line over through a small line control register. Each line has its own override enable and a level bit. The register also reports the live, synchronized levels of both lines, so software can see whether a target is holding SDA low.

A built-in recovery sequencer frees a bus whose SDA is held low by a target. The target was left partway through a byte. The sequencer takes SCL, samples SDA three cycles in a row and stops as soon as all three samples read high. Otherwise it drives one SCL low-then-high pulse and samples again, for at most nine pulses. When it finishes it raises a one-cycle done pulse, reports pass or fail, and returns SCL to the core. While it runs, START requests from the core are held off. Recovery is accepted only while the core reports itself idle.

Top module: `i2c_line_ctl`

## Requirements
- R1: After reset, with both pads high and no override, `lcr_rdata_o` reads 0x3A, and the pad drive levels follow `core_scl_i` and `core_sda_i`.
- R2: Register bit 0 enables the SDA override. While it is set, `pad_sda_o` equals register bit 1 regardless of the core.
- R3: Register bit 2 enables the SCL override. While it is set, `pad_scl_o` equals register bit 3, which reads back in bit 3.
- R4: Read bit 4 shows the SDA pad level and read bit 5 the SCL pad level, each delayed by SYNC_STAGES clock cycles.
- R5: A recovery start pulse is acted on only while `core_idle_i` is high and no recovery is running. Otherwise it has no effect, and `rec_busy_o` and `rec_done_o` stay low.
- R6: While `rec_busy_o` is high, `core_start_gnt_o` is low even if `core_start_req_i` is high. Otherwise it equals the request.
- R7: Before every SCL pulse the sequencer samples SDA on three consecutive cycles. If all three samples are high it finishes with success and drives no pulse, so a free bus sees zero pulses.
- R8: Each recovery SCL low phase and high phase lasts `rec_phase_i` cycles, or PHASE_DEFAULT cycles (1250 by default) when `rec_phase_i` is zero. The value is captured at start.
- R9: Recovery drives at most nine SCL pulses. If SDA is still low after the ninth pulse, `rec_fail_o` is high at done.
- R10: If the target releases SDA after the k-th pulse (k ≤ 9), recovery ends after exactly k pulses with `rec_fail_o` low.
- R11: `rec_done_o` is high for exactly one cycle per recovery. `rec_fail_o` holds its result until the next start. The SCL override enable (bit 2) reads 0 after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_scl_i | input | 1 | SCL drive level from the master core (1 = release) |
| core_sda_i | input | 1 | SDA drive level from the master core (1 = release) |
| core_idle_i | input | 1 | Master core reports no transfer in progress |
| core_start_req_i | input | 1 | Core asks to issue a START |
| core_start_gnt_o | output | 1 | START permitted |
| pad_scl_i | input | 1 | Sensed SCL pad level |
| pad_sda_i | input | 1 | Sensed SDA pad level |
| pad_scl_o | output | 1 | SCL drive level to the pad (0 = pull low) |
| pad_sda_o | output | 1 | SDA drive level to the pad (0 = pull low) |
| lcr_we_i | input | 1 | Write strobe for the line control register |
| lcr_wdata_i | input | 4 | Write data: bit0 SDA enable, bit1 SDA level, bit2 SCL enable, bit3 SCL level |
| lcr_rdata_o | output | 6 | Register read value, bits 4 and 5 are live line levels |
| rec_start_i | input | 1 | Request a recovery sequence |
| rec_phase_i | input | PH_W | Length of each SCL phase in cycles, 0 selects the default |
| rec_busy_o | output | 1 | Recovery in progress |
| rec_done_o | output | 1 | One-cycle pulse at the end of recovery |
| rec_fail_o | output | 1 | Last recovery ended with SDA still low |

## Verification
The bench models a target that holds SDA low until it has seen a chosen number of SCL rising edges. It runs recovery with zero, three, nine and twelve held edges. A sequencer that pulsed before sampling, stopped one pulse early or late, or misreported the nine-pulse boundary would give the wrong pulse count or flag. Every low phase is timed against the programmed and the default length, which catches an off-by-one phase counter. The bench also checks that a start while the core is busy is ignored, that the core is denied START only during recovery, and that a software SCL override is found cleared after done. A design that left SCL held after recovery would fail that last check.

// File: rtl/i2c_lc_pkg.sv
package i2c_lc_pkg;
    localparam int LCR_W      = 6;
    localparam int B_SDA_EN   = 0;
    localparam int B_SDA_LVL  = 1;
    localparam int B_SCL_EN   = 2;
    localparam int B_SCL_LVL  = 3;
    localparam int B_SDA_SEEN = 4;
    localparam int B_SCL_SEEN = 5;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_SAMP = 2'd1,
        RS_LOW  = 2'd2,
        RS_HIGH = 2'd3
    } rec_state_e;
endpackage

// File: rtl/i2c_lc_sync.sv
module i2c_lc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= RST_VAL;
                else        sh_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_lc_regs.sv
module i2c_lc_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [3:0] wdata_i,
    input  logic       clr_scl_en_i,
    output logic       sda_en_o,
    output logic       sda_lvl_o,
    output logic       scl_en_o,
    output logic       scl_lvl_o
);
    import i2c_lc_pkg::*;

    typedef struct packed {
        logic sda_en;
        logic sda_lvl;
        logic scl_en;
        logic scl_lvl;
    } lcr_t;

    lcr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            r_d.sda_en  = wdata_i[B_SDA_EN];
            r_d.sda_lvl = wdata_i[B_SDA_LVL];
            r_d.scl_en  = wdata_i[B_SCL_EN];
            r_d.scl_lvl = wdata_i[B_SCL_LVL];
        end
        // end of recovery hands SCL back to the core
        if (clr_scl_en_i) r_d.scl_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sda_en: 1'b0, sda_lvl: 1'b1, scl_en: 1'b0, scl_lvl: 1'b1};
        else        r_q <= r_d;
    end

    assign sda_en_o  = r_q.sda_en;
    assign sda_lvl_o = r_q.sda_lvl;
    assign scl_en_o  = r_q.scl_en;
    assign scl_lvl_o = r_q.scl_lvl;

    AST_OVR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_scl_en_i |=> !scl_en_o); // R11
endmodule

// File: rtl/i2c_lc_seq.sv
module i2c_lc_seq #(
    parameter int MAX_PULSES = 9,
    parameter int SAMPLES    = 3,
    parameter int PH_W       = 12,
    parameter int PH_DEFAULT = 1250
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            core_idle_i,
    input  logic            sda_i,
    input  logic [PH_W-1:0] phase_len_i,
    output logic            busy_o,
    output logic            scl_o,
    output logic            done_o,
    output logic            fail_o
);
    import i2c_lc_pkg::*;

    localparam int PC_W = $clog2(MAX_PULSES + 1);
    localparam int SC_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

    typedef struct packed {
        rec_state_e      st;
        logic [SC_W-1:0] samp;
        logic            all_hi;
        logic [PC_W-1:0] pulses;
        logic [PH_W-1:0] ph;
        logic [PH_W-1:0] ph_last;
        logic            done;
        logic            fail;
    } seq_t;

    seq_t s_d, s_q;
    logic hi_now;
    logic [PH_W-1:0] len_eff;

    assign len_eff = (phase_len_i == '0) ? PH_W'(PH_DEFAULT) : phase_len_i;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        hi_now   = s_q.all_hi & sda_i;
        unique case (s_q.st)
            RS_IDLE: begin
                if (start_i && core_idle_i) begin
                    s_d.st      = RS_SAMP;
                    s_d.samp    = '0;
                    s_d.all_hi  = 1'b1;
                    s_d.pulses  = '0;
                    s_d.fail    = 1'b0;
                    s_d.ph_last = len_eff - 1'b1;
                end
            end
            RS_SAMP: begin
                if (s_q.samp == SC_W'(SAMPLES - 1)) begin
                    if (hi_now || s_q.pulses == PC_W'(MAX_PULSES)) begin
                        s_d.st   = RS_IDLE;
                        s_d.done = 1'b1;
                        s_d.fail = ~hi_now;
                    end else begin
                        s_d.st = RS_LOW;
                        s_d.ph = '0;
                    end
                end else begin
                    s_d.samp   = s_q.samp + 1'b1;
                    s_d.all_hi = hi_now;
                end
            end
            RS_LOW: begin
                if (s_q.ph == s_q.ph_last) begin
                    s_d.st = RS_HIGH;
                    s_d.ph = '0;
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            RS_HIGH: begin
                if (s_q.ph == s_q.ph_last) begin
                    s_d.st     = RS_SAMP;
                    s_d.samp   = '0;
                    s_d.all_hi = 1'b1;
                    s_d.pulses = s_q.pulses + 1'b1;
                end else begin
                    s_d.ph = s_q.ph + 1'b1;
                end
            end
            default: s_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RS_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.st != RS_IDLE);
    assign scl_o  = (s_q.st != RS_LOW);
    assign done_o = s_q.done;
    assign fail_o = s_q.fail;

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulses <= PC_W'(MAX_PULSES)); // R9
    AST_LOW_AFTER_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RS_LOW && $past(s_q.st) != RS_LOW) |->
        ($past(s_q.st) == RS_SAMP && $past(s_q.samp) == SC_W'(SAMPLES - 1))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done); // R11
    AST_OK_SEES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !s_q.fail) |-> $past(sda_i)); // R10
    AST_FAIL_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && s_q.fail) |-> s_q.pulses == PC_W'(MAX_PULSES)); // R9
endmodule

// File: rtl/i2c_line_ctl.sv
module i2c_line_ctl #(
    parameter int SYNC_STAGES   = 2,
    parameter int MAX_PULSES    = 9,
    parameter int SAMPLES       = 3,
    parameter int PH_W          = 12,
    parameter int PHASE_DEFAULT = 1250
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            core_scl_i,
    input  logic            core_sda_i,
    input  logic            core_idle_i,
    input  logic            core_start_req_i,
    output logic            core_start_gnt_o,
    input  logic            pad_scl_i,
    input  logic            pad_sda_i,
    output logic            pad_scl_o,
    output logic            pad_sda_o,
    input  logic            lcr_we_i,
    input  logic [3:0]      lcr_wdata_i,
    output logic [5:0]      lcr_rdata_o,
    input  logic            rec_start_i,
    input  logic [PH_W-1:0] rec_phase_i,
    output logic            rec_busy_o,
    output logic            rec_done_o,
    output logic            rec_fail_o
);
    import i2c_lc_pkg::*;

    logic sda_seen, scl_seen;
    logic sda_en, sda_lvl, scl_en, scl_lvl;
    logic seq_busy, seq_scl, seq_done, seq_fail;

    i2c_lc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(pad_sda_i), .q_o(sda_seen));
    i2c_lc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(pad_scl_i), .q_o(scl_seen));

    i2c_lc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(lcr_we_i), .wdata_i(lcr_wdata_i), .clr_scl_en_i(seq_done),
        .sda_en_o(sda_en), .sda_lvl_o(sda_lvl),
        .scl_en_o(scl_en), .scl_lvl_o(scl_lvl));

    i2c_lc_seq #(
        .MAX_PULSES(MAX_PULSES), .SAMPLES(SAMPLES),
        .PH_W(PH_W), .PH_DEFAULT(PHASE_DEFAULT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(rec_start_i), .core_idle_i(core_idle_i),
        .sda_i(sda_seen), .phase_len_i(rec_phase_i),
        .busy_o(seq_busy), .scl_o(seq_scl),
        .done_o(seq_done), .fail_o(seq_fail));

    always_comb begin
        if (seq_busy)    pad_scl_o = seq_scl;
        else if (scl_en) pad_scl_o = scl_lvl;
        else             pad_scl_o = core_scl_i;
        pad_sda_o = sda_en ? sda_lvl : core_sda_i;
    end

    always_comb begin
        lcr_rdata_o             = '0;
        lcr_rdata_o[B_SDA_EN]   = sda_en;
        lcr_rdata_o[B_SDA_LVL]  = sda_lvl;
        lcr_rdata_o[B_SCL_EN]   = scl_en | seq_busy;
        lcr_rdata_o[B_SCL_LVL]  = seq_busy ? seq_scl : scl_lvl;
        lcr_rdata_o[B_SDA_SEEN] = sda_seen;
        lcr_rdata_o[B_SCL_SEEN] = scl_seen;
    end

    assign core_start_gnt_o = core_start_req_i & ~seq_busy;
    assign rec_busy_o       = seq_busy;
    assign rec_done_o       = seq_done;
    assign rec_fail_o       = seq_fail;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(core_idle_i)); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !seq_busy); // R11
endmodule

// File: tb/i2c_line_ctl_tb.sv
module i2c_line_ctl_tb;
    localparam int PH_W = 12;
    localparam int PH_DEF = 1250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_scl = 1'b1, core_sda = 1'b1, core_idle = 1'b1, core_req = 1'b0;
    logic core_gnt;
    logic pad_scl_i, pad_sda_i, pad_scl_o, pad_sda_o;
    logic lcr_we = 1'b0;
    logic [3:0] lcr_wdata = 4'b1010;
    logic [5:0] lcr_rdata;
    logic rec_start = 1'b0;
    logic [PH_W-1:0] rec_phase = '0;
    logic rec_busy, rec_done, rec_fail;

    always #2 clk = ~clk;

    int tgt_hold = 0, tgt_base = 0, tgt_rises = 0;
    logic prev_scl = 1'b1;
    logic tgt_sda;
    assign tgt_sda   = ((tgt_rises - tgt_base) >= tgt_hold);
    assign pad_sda_i = pad_sda_o & tgt_sda;
    assign pad_scl_i = pad_scl_o;

    i2c_line_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_scl_i(core_scl), .core_sda_i(core_sda), .core_idle_i(core_idle),
        .core_start_req_i(core_req), .core_start_gnt_o(core_gnt),
        .pad_scl_i(pad_scl_i), .pad_sda_i(pad_sda_i),
        .pad_scl_o(pad_scl_o), .pad_sda_o(pad_sda_o),
        .lcr_we_i(lcr_we), .lcr_wdata_i(lcr_wdata), .lcr_rdata_o(lcr_rdata),
        .rec_start_i(rec_start), .rec_phase_i(rec_phase),
        .rec_busy_o(rec_busy), .rec_done_o(rec_done), .rec_fail_o(rec_fail));

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct { bit fail; int pulses; int len; } exp_t;
    exp_t exp_q[$];
    int low_cnt = 0, pulse_cnt = 0;

    // monitor: pulse widths, pulse count, result on done; also target edge counter
    initial begin
        forever begin
            @(negedge clk);
            if (pad_scl_o && !prev_scl) tgt_rises++;
            prev_scl = pad_scl_o;
            if (rec_busy) begin
                if (!pad_scl_o) low_cnt++;
                else if (low_cnt > 0) begin
                    if (exp_q.size() > 0) check("R8 low phase width", low_cnt, exp_q[0].len);
                    pulse_cnt++;
                    low_cnt = 0;
                end
            end
            if (rec_done) begin
                if (exp_q.size() == 0) check("R5 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R9/R10 pulse count", pulse_cnt, e.pulses);
                    check("R9/R10 fail flag", int'(rec_fail), int'(e.fail));
                end
                pulse_cnt = 0;
                low_cnt = 0;
            end
        end
    end

    task automatic wr(logic [3:0] v);
        @(negedge clk); lcr_we = 1'b1; lcr_wdata = v;
        @(negedge clk); lcr_we = 1'b0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_rec(int hold, int ph, int len);
        exp_t e;
        @(negedge clk);
        tgt_base = tgt_rises;
        tgt_hold = hold;
        e.fail = (hold > 9);
        e.pulses = (hold > 9) ? 9 : hold;
        e.len = len;
        exp_q.push_back(e);
        rec_phase = PH_W'(ph);
        rec_start = 1'b1;
        @(negedge clk); rec_start = 1'b0;
        wait (exp_q.size() == 0);
        cyc(3);
        tgt_hold = 0;
        check("R11 SCL override released", int'(lcr_rdata[2]), 0);
        check("R11 fail held", int'(rec_fail), int'(e.fail));
        check("R11 busy cleared", int'(rec_busy), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        check("R1 reset readback", int'(lcr_rdata), 32'h3A);
        check("R1 scl follows core", int'(pad_scl_o), 1);
        core_scl = 1'b0; core_sda = 1'b0; #0;
        cyc(1);
        check("R1 scl follows core low", int'(pad_scl_o), 0);
        check("R1 sda follows core low", int'(pad_sda_o), 0);
        core_scl = 1'b1; core_sda = 1'b1;
        cyc(4);

        // R2 SDA override low, core releases
        wr(4'b1001);
        check("R2 sda override low", int'(pad_sda_o), 0);
        cyc(3);
        check("R4 sda readback low", int'(lcr_rdata[4]), 0);
        wr(4'b1011);
        check("R2 sda override high", int'(pad_sda_o), 1);
        cyc(3);
        check("R4 sda readback high", int'(lcr_rdata[4]), 1);

        // R3 SCL override low
        wr(4'b0110);
        check("R3 scl override low", int'(pad_scl_o), 0);
        check("R3 scl level readback", int'(lcr_rdata[3]), 0);
        check("R3 scl enable readback", int'(lcr_rdata[2]), 1);
        cyc(3);
        check("R4 scl readback low", int'(lcr_rdata[5]), 0);
        wr(4'b1010);
        cyc(3);
        check("R4 scl readback high", int'(lcr_rdata[5]), 1);

        // R5 start ignored while core busy
        core_idle = 1'b0;
        @(negedge clk); rec_start = 1'b1;
        @(negedge clk); rec_start = 1'b0;
        cyc(3);
        check("R5 start ignored when core busy", int'(rec_busy), 0);
        core_idle = 1'b1;

        // R7 free bus: no pulse
        run_rec(0, 3, 3);
        // R6 gate during recovery
        core_req = 1'b1;
        fork
            run_rec(3, 5, 5);
            begin
                cyc(4);
                check("R6 start blocked while busy", int'(core_gnt), 0);
            end
        join
        cyc(1);
        check("R6 start granted when idle", int'(core_gnt), 1);
        core_req = 1'b0;
        // R9 boundary: release on the ninth pulse
        run_rec(9, 3, 3);
        // R11 software SCL override cleared by done; R9 fail case
        wr(4'b1110);
        run_rec(12, 4, 4);
        // R8 default phase length
        run_rec(2, 0, PH_DEF);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule